// File: doc/BRIEF.md
# Gated-Clock Reload Timer with Duty PWM

This block is a 16-bit up-counting timer for a sound-oriented controller. The counter advances only in system cycles in which two selected enable strobes are both active. One strobe comes from a fast group: the PLL strobe, the external strobe, a constant 0 or a constant 1. The other comes from a slow group: the RTC strobe, the 64 Hz, 16 Hz and 2 Hz strobes, or a constant 1. All strobes are single-cycle pulses that are already in the system clock domain. The counter therefore moves by at most one per system cycle.

Software sets up the timer through a small register port. It writes a preload value first. A write to the count address then loads that preload into the counter. From there the counter climbs to the all-ones value, wraps back to the preload, and emits a one-cycle pulse on the interrupt output. The same pulse goes out on a timeout output, which can trigger a DAC sample latch or an ADC conversion.

Each timeout also advances a 16-step PWM phase. The PWM output is high for the first `duty` phases of every 16 timeouts.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset, the preload, count and control registers read as 0, and `irq`, `timeout` and `pwm_out` are low.
- R2: Register addresses are decoded as follows. A write to address 0 sets the preload. A write to address 1 copies the preload into the counter on that clock edge. Address 2 holds the control register: the select field is in bits [4:0] and the PWM duty is in bits [11:8]. A read returns the addressed register (address 1 returns the live count) on `rd_data` one clock after `bus_addr` is presented.
- R3: In a cycle where the gated enable is high, the count rises by exactly one. In any other cycle without a count write, the count holds.
- R4: Control bits [4:3] choose the fast source: 00 is constant 0, 01 is constant 1, 10 is the PLL strobe, 11 is the external strobe. Constant 0 stops the counter whatever the strobes do.
- R5: Control bits [2:0] choose the slow source: 000 is RTC, 001 is 64 Hz, 010 is 16 Hz, 011 is 2 Hz, and any other value is constant 1. The gated enable is the AND of the fast and slow choices.
- R6: An enabled cycle with the count at 0xFFFF reloads the preload instead of reaching 0x0000. In the next cycle, `irq` and `timeout` are both high for that one cycle.
- R7: A count write in the same cycle as a wrap takes precedence. The counter takes the preload, and no `irq` or `timeout` pulse is produced.
- R8: A 4-bit PWM phase, cleared by reset, advances by one with each timeout and wraps after 15. For duty values 1 to 14, `pwm_out` is high while the phase is below the duty, so it is high for `duty` out of every 16 timeouts. The output is registered and follows the new phase one cycle after the timeout pulse.
- R9: A duty of 0, or any duty above 14, holds `pwm_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| pll_stb | input | 1 | Fast PLL-derived enable strobe |
| ext_stb | input | 1 | External clock enable strobe |
| rtc_stb | input | 1 | RTC enable strobe |
| hz64_stb | input | 1 | 64 Hz enable strobe |
| hz16_stb | input | 1 | 16 Hz enable strobe |
| hz2_stb | input | 1 | 2 Hz enable strobe |
| irq | output | 1 | One-cycle interrupt pulse on wrap |
| timeout | output | 1 | One-cycle timeout strobe, used as a DAC/ADC trigger |
| pwm_out | output | 1 | 16-step duty PWM output |

## Verification
A write to the count register and a wrap of the counter can fall on the same clock edge. The bench provokes this by parking the counter at 0xFFFF, changing the preload, and then raising the PLL strobe in the very cycle that the count write is issued. The expected result is that the new preload is in the counter and that `irq` stays low in the following cycle. The bench also drives a plain wrap on its own, so that the pulse it does expect there separates the two cases.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_PRELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;

  typedef enum logic [1:0] {
    FAST_OFF = 2'b00,
    FAST_ON  = 2'b01,
    FAST_PLL = 2'b10,
    FAST_EXT = 2'b11
  } fast_src_e;

  typedef enum logic [2:0] {
    SLOW_RTC  = 3'b000,
    SLOW_64HZ = 3'b001,
    SLOW_16HZ = 3'b010,
    SLOW_2HZ  = 3'b011,
    SLOW_ON   = 3'b100
  } slow_src_e;
endpackage

// File: rtl/gtmr_tick_sel.sv
module gtmr_tick_sel
  import gtmr_pkg::*;
(
  input  logic [1:0] fast_sel,
  input  logic [2:0] slow_sel,
  input  logic       pll_stb,
  input  logic       ext_stb,
  input  logic       rtc_stb,
  input  logic       hz64_stb,
  input  logic       hz16_stb,
  input  logic       hz2_stb,
  output logic       tick
);
  logic fast_en, slow_en;

  always_comb begin
    unique case (fast_src_e'(fast_sel))
      FAST_OFF: fast_en = 1'b0;
      FAST_ON:  fast_en = 1'b1;
      FAST_PLL: fast_en = pll_stb;
      default:  fast_en = ext_stb;
    endcase
  end

  always_comb begin
    case (slow_sel)
      SLOW_RTC:  slow_en = rtc_stb;
      SLOW_64HZ: slow_en = hz64_stb;
      SLOW_16HZ: slow_en = hz16_stb;
      SLOW_2HZ:  slow_en = hz2_stb;
      default:   slow_en = 1'b1;
    endcase
  end

  assign tick = fast_en & slow_en;
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (load) begin
        count <= preload;
      end else if (tick) begin
        if (count == TOP) begin
          count <= preload;
          wrap  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count != TOP) |=> (count == $past(count) + 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(count)); // R3
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && count == TOP) |=> (wrap && count == $past(preload))); // R6
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (!wrap && count == $past(preload))); // R7
endmodule

// File: rtl/gtmr_pwm.sv
module gtmr_pwm #(
  parameter int unsigned PH_W     = 4,
  parameter int unsigned MAX_DUTY = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [PH_W-1:0] duty,
  output logic            pwm
);
  logic [PH_W-1:0] phase, phase_nx;
  logic            duty_ok;

  assign duty_ok  = (duty != '0) && (duty <= PH_W'(MAX_DUTY));
  assign phase_nx = step ? phase + 1'b1 : phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pwm   <= 1'b0;
    end else begin
      phase <= phase_nx;
      pwm   <= duty_ok && (phase_nx < duty);
    end
  end

  AST_PWM_OFF: assert property (@(posedge clk) disable iff (rst)
    !duty_ok |=> !pwm); // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase)); // R8
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer
  import gtmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PH_W     = 4,
  parameter int unsigned MAX_DUTY = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              pll_stb,
  input  logic              ext_stb,
  input  logic              rtc_stb,
  input  logic              hz64_stb,
  input  logic              hz16_stb,
  input  logic              hz2_stb,
  output logic              irq,
  output logic              timeout,
  output logic              pwm_out
);
  localparam int unsigned SEL_W  = 5;
  localparam int unsigned DUTY_LO = 8;

  logic [CNT_W-1:0] preload_q;
  logic [SEL_W-1:0] sel_q;
  logic [PH_W-1:0]  duty_q;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_load, tick, wrap;
  logic [CNT_W-1:0] ctrl_view;

  assign cnt_load = bus_we && (bus_addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= '0;
      sel_q     <= '0;
      duty_q    <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_PRELOAD) preload_q <= bus_wdata;
      if (bus_addr == A_CTRL) begin
        sel_q  <= bus_wdata[SEL_W-1:0];
        duty_q <= bus_wdata[DUTY_LO +: PH_W];
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[SEL_W-1:0]       = sel_q;
    ctrl_view[DUTY_LO +: PH_W] = duty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (bus_addr)
        A_PRELOAD: rd_data <= preload_q;
        A_COUNT:   rd_data <= cnt_val;
        A_CTRL:    rd_data <= ctrl_view;
        default:   rd_data <= '0;
      endcase
    end
  end

  gtmr_tick_sel u_sel (
    .fast_sel (sel_q[4:3]),
    .slow_sel (sel_q[2:0]),
    .pll_stb  (pll_stb),
    .ext_stb  (ext_stb),
    .rtc_stb  (rtc_stb),
    .hz64_stb (hz64_stb),
    .hz16_stb (hz16_stb),
    .hz2_stb  (hz2_stb),
    .tick     (tick)
  );

  gtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .load    (cnt_load),
    .preload (preload_q),
    .count   (cnt_val),
    .wrap    (wrap)
  );

  gtmr_pwm #(.PH_W(PH_W), .MAX_DUTY(MAX_DUTY)) u_pwm (
    .clk  (clk),
    .rst  (rst),
    .step (wrap),
    .duty (duty_q),
    .pwm  (pwm_out)
  );

  assign irq     = wrap;
  assign timeout = wrap;

  AST_FAST_OFF_STOPS: assert property (@(posedge clk) disable iff (rst)
    (sel_q[4:3] == 2'b00 && !cnt_load) |=> $stable(cnt_val)); // R4
  AST_SLOW_GATES: assert property (@(posedge clk) disable iff (rst)
    (sel_q[2:0] == 3'b001 && !hz64_stb && !cnt_load) |=> $stable(cnt_val)); // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> (cnt_val == $past(preload_q) && !irq)); // R2
endmodule

// File: tb/gated_reload_timer_test.sv
module gated_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] rd_data;
  logic [5:0]  stb;
  logic        irq, timeout, pwm_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gated_reload_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data),
    .pll_stb(stb[0]), .ext_stb(stb[1]), .rtc_stb(stb[2]),
    .hz64_stb(stb[3]), .hz16_stb(stb[4]), .hz2_stb(stb[5]),
    .irq(irq), .timeout(timeout), .pwm_out(pwm_out)
  );

  // {select[4:0], strobe mask {2Hz,16Hz,64Hz,RTC,EXT,PLL}, cycles[3:0]}
  localparam logic [14:0] VEC [9] = '{
    {5'b00100, 6'h3F, 4'd5},
    {5'b01000, 6'h04, 4'd7},
    {5'b10100, 6'h01, 4'd4},
    {5'b10100, 6'h02, 4'd4},
    {5'b11000, 6'h06, 4'd6},
    {5'b11001, 6'h06, 4'd6},
    {5'b01010, 6'h10, 4'd3},
    {5'b01011, 6'h20, 4'd9},
    {5'b10011, 6'h01, 4'd5}
  };

  function automatic bit gate_on(input logic [4:0] sel, input logic [5:0] m);
    bit f, s;
    case (sel[4:3])
      2'b00: f = 0;
      2'b01: f = 1;
      2'b10: f = m[0];
      default: f = m[1];
    endcase
    case (sel[2:0])
      3'b000: s = m[2];
      3'b001: s = m[3];
      3'b010: s = m[4];
      3'b011: s = m[5];
      default: s = 1;
    endcase
    return f && s;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse(input logic [5:0] m, input int n);
    @(negedge clk);
    stb = m;
    repeat (n) @(negedge clk);
    stb = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int highs;
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; stb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 pwm", {15'b0, pwm_out}, 16'h0);
    rd(2'd0, v); check("R1 preload", v, 16'h0);
    rd(2'd1, v); check("R1 count", v, 16'h0);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0);

    // R2 register readback
    wr(2'd2, 16'h0D13);
    rd(2'd2, v); check("R2 ctrl readback", v, 16'h0D13);

    // R3/R4/R5 vector walk
    for (int i = 0; i < 9; i++) begin
      logic [4:0] sel;
      logic [5:0] m;
      logic [3:0] k;
      logic [15:0] base, exp;
      {sel, m, k} = VEC[i];
      base = 16'h0100 + 16'(i) * 16'h10;
      wr(2'd2, {11'b0, sel});
      wr(2'd0, base);
      wr(2'd1, 16'h0);
      pulse(m, int'(k));
      exp = gate_on(sel, m) ? base + 16'(k) : base;
      rd(2'd1, v);
      check($sformatf("R3/R4/R5 vec%0d count", i), v, exp);
    end

    // R6 wrap and reload
    wr(2'd2, 16'h0014);
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0);
    pulse(6'h01, 1);
    check("R6 no irq before wrap", {15'b0, irq}, 16'h0);
    pulse(6'h01, 1);
    check("R6 irq on wrap", {15'b0, irq}, 16'h1);
    check("R6 timeout on wrap", {15'b0, timeout}, 16'h1);
    @(negedge clk);
    check("R6 irq single cycle", {15'b0, irq}, 16'h0);
    rd(2'd1, v); check("R6 reload value", v, 16'hFFFE);

    // R7 count write coincides with wrap
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0);
    wr(2'd0, 16'h1234);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd1; stb = 6'h01;
    @(negedge clk);
    bus_we = 1'b0; stb = '0;
    check("R7 no irq on collision", {15'b0, irq}, 16'h0);
    check("R7 no timeout on collision", {15'b0, timeout}, 16'h0);
    rd(2'd1, v); check("R7 write wins", v, 16'h1234);

    // R8 PWM duty 3
    do_reset();
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0);
    wr(2'd2, 16'h0314);
    @(negedge clk);
    check("R8 pwm phase0", {15'b0, pwm_out}, 16'h1);
    highs = 0;
    for (int k = 0; k < 32; k++) begin
      bit e;
      pulse(6'h01, 1);
      @(negedge clk);
      e = ((k + 1) % 16) < 3;
      if (pwm_out) highs++;
      check($sformatf("R8 pwm step%0d", k), {15'b0, pwm_out}, {15'b0, e});
    end
    check("R8 duty3 highs per 32", 16'(highs), 16'd6);

    // R8 duty 14
    wr(2'd2, 16'h0E14);
    highs = 0;
    for (int k = 0; k < 16; k++) begin
      pulse(6'h01, 1);
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check("R8 duty14 highs", 16'(highs), 16'd14);

    // R9 duty 15 and duty 0 force low
    wr(2'd2, 16'h0F14);
    highs = 0;
    for (int k = 0; k < 16; k++) begin
      pulse(6'h01, 1);
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check("R9 duty15 low", 16'(highs), 16'd0);
    wr(2'd2, 16'h0014);
    highs = 0;
    for (int k = 0; k < 16; k++) begin
      pulse(6'h01, 1);
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check("R9 duty0 low", 16'(highs), 16'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule